// File: doc/BRIEF.md
# Trigger Delay and Readout Controller

This block turns a level-1 trigger strobe into word-serial readout packets. When a trigger arrives, a delay counter waits 32 plus a 4-bit programmable offset in clock ticks. A sequencer then reads a fixed number of sample pairs from an external store through a word address, and a formatter puts each word on the output stream. Every packet is framed by a start pulse on its first word and an end pulse on its last word.

Two configuration bits select the packet content. With raw mode off, the block sends one packet per trigger holding post-sample minus pre-sample, as a signed value one bit wider than a sample. With raw mode on, it sends two back-to-back packets: the pre-samples, then the post-samples. With test-count mode on, every data word is replaced by its position in the packet, counting from 1. A trigger that arrives while a readout is running is held in a small pending counter and serviced later in arrival order. A trigger that would overflow that counter is dropped and sets a sticky flag.

Top module: `trig_readout_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `pkt_valid`, `pkt_sop`, `pkt_eop` and `pend_ovf` are 0.
- R2: With the block idle, a trigger sampled on clock edge e gives a first word with `pkt_valid` high right after edge e+32+`cfg_delay`. Each cycle with `l1_trig` high counts as one trigger.
- R3: With raw mode 0 and test mode 0, one packet of WORDS words is sent per trigger. Word i is post[i] minus pre[i] as an 11-bit two's-complement value, where pre[i] and post[i] are the samples presented while `samp_addr` = i.
- R4: With raw mode 1 and test mode 0, two packets follow one another with no idle cycle. The first carries pre[i] zero-extended to 11 bits and the second carries post[i] zero-extended.
- R5: With test mode 1, word i of every packet is i+1, restarting at 1 in each packet, and the sample inputs are ignored. Raw mode still chooses one packet or two.
- R6: `pkt_sop` is high only on the first word of a packet and `pkt_eop` only on the last. `pkt_valid` stays high without a gap from the first word to the last.
- R7: `samp_addr` gives the index of the word being read, so word i of the output uses the samples presented for address i.
- R8: A trigger that arrives during a readout (delay or packet phase) is queued. Its own readout starts after the current one ends: its start pulse comes 33+`cfg_delay` cycles after the previous end pulse.
- R9: At most 2^PEND_W-1 triggers are held pending (3 by default). A trigger beyond that is dropped, produces no readout, and sets `pend_ovf`, which stays 1 until reset.
- R10: The delay field, raw mode and test mode are captured when a readout's delay starts. Changing them during that readout has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_trig | input | 1 | Level-1 trigger strobe, one trigger per cycle high |
| cfg_delay | input | DLY_W (4) | Delay offset added to the 32-tick base |
| cfg_test_count | input | 1 | 1 = replace data with 1, 2, 3, ... |
| cfg_raw_mode | input | 1 | 0 = one difference packet, 1 = pre then post packets |
| samp_addr | output | IDX_W (3) | Index of the sample pair being read |
| pre_sample | input | SAMPLE_W (10) | Pre-sample at `samp_addr`, unsigned |
| post_sample | input | SAMPLE_W (10) | Post-sample at `samp_addr`, unsigned |
| pkt_valid | output | 1 | Output word valid |
| pkt_data | output | SAMPLE_W+1 (11) | Output data word |
| pkt_sop | output | 1 | First word of packet |
| pkt_eop | output | 1 | Last word of packet |
| pend_ovf | output | 1 | Sticky: a trigger was dropped |

## Verification
The sample store is modelled in the bench as a function of `samp_addr`. It is driven with four patterns: an address-and-seed mix, an all-high pre against an all-zero post, the reverse of that, and ramps. Together they separate a correct signed difference from swapped operands, lost sign bits and wrong address alignment. Latency is measured for delay offsets of 0, 7 and 15, which separates the 32-tick base and the offset from off-by-one counting. Raw mode and test mode are tried on their own and together. Queued and overflowing trigger bursts check the pending limit, the drop of the extra trigger and the gap between readouts. A reconfiguration during a readout shows that the captured settings are the ones used.

// File: rtl/trd_pkg.sv
package trd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        WK_DIFF  = 2'd0,
        WK_PRE   = 2'd1,
        WK_POST  = 2'd2,
        WK_COUNT = 2'd3
    } word_kind_e;

    typedef struct packed {
        logic raw;
        logic test;
    } rd_cfg_t;

    // choose what a data word carries from the captured mode and packet index
    function automatic word_kind_e pick_kind(input rd_cfg_t cfg, input logic second_pkt);
        if (cfg.test)
            return WK_COUNT;
        else if (!cfg.raw)
            return WK_DIFF;
        else if (second_pkt)
            return WK_POST;
        else
            return WK_PRE;
    endfunction

endpackage

// File: rtl/trd_trig_queue.sv
module trd_trig_queue #(
    parameter int PEND_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic start,
    output logic have_pend,
    output logic ovf
);
    localparam int PMAX = (1 << PEND_W) - 1;

    logic [PEND_W-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            ovf  <= 1'b0;
        end else begin
            if (trig && !start) begin
                if (pend == PEND_W'(PMAX))
                    ovf <= 1'b1;
                else
                    pend <= pend + 1'b1;
            end else if (start && !trig) begin
                pend <= pend - 1'b1;
            end
        end
    end

    assign have_pend = (pend != '0);

endmodule

// File: rtl/trd_delay.sv
module trd_delay #(
    parameter int DLY_W    = 4,
    parameter int DLY_BASE = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] dly,
    output logic             done
);
    localparam int CNT_W = $clog2(DLY_BASE + (1 << DLY_W));

    logic [CNT_W-1:0] cnt;

    // loaded two short of the total: one cycle is lost to the wait-to-send
    // transition and one to the output register
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(DLY_BASE - 2) + CNT_W'(dly);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/trd_seq.sv
module trd_seq
    import trd_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             have_pend,
    input  logic             dly_done,
    input  rd_cfg_t          cfg_in,
    output logic             start,
    output logic             emit,
    output logic             last,
    output logic [IDX_W-1:0] word_idx,
    output logic             second_pkt,
    output rd_cfg_t          cfg_q
);
    seq_state_e st;

    assign start = (st == ST_IDLE) && (trig || have_pend);
    assign emit  = (st == ST_SEND);
    assign last  = (word_idx == IDX_W'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            word_idx   <= '0;
            second_pkt <= 1'b0;
            cfg_q      <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st         <= ST_WAIT;
                        cfg_q      <= cfg_in;
                        word_idx   <= '0;
                        second_pkt <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (dly_done)
                        st <= ST_SEND;
                end
                ST_SEND: begin
                    if (last) begin
                        word_idx <= '0;
                        if (cfg_q.raw && !second_pkt) begin
                            second_pkt <= 1'b1;
                        end else begin
                            second_pkt <= 1'b0;
                            st         <= ST_IDLE;
                        end
                    end else begin
                        word_idx <= word_idx + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/trd_word_gen.sv
module trd_word_gen
    import trd_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                emit,
    input  logic                last,
    input  logic [IDX_W-1:0]    word_idx,
    input  logic                second_pkt,
    input  rd_cfg_t             cfg,
    input  logic [SAMPLE_W-1:0] pre,
    input  logic [SAMPLE_W-1:0] post,
    output logic                valid,
    output logic [SAMPLE_W:0]   data,
    output logic                sop,
    output logic                eop
);
    localparam int DW = SAMPLE_W + 1;

    word_kind_e    kind;
    logic [DW-1:0] word;

    assign kind = pick_kind(cfg, second_pkt);

    always_comb begin
        unique case (kind)
            WK_DIFF:  word = {1'b0, post} - {1'b0, pre};
            WK_PRE:   word = {1'b0, pre};
            WK_POST:  word = {1'b0, post};
            WK_COUNT: word = DW'(word_idx) + DW'(1);
            default:  word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            sop   <= 1'b0;
            eop   <= 1'b0;
            data  <= '0;
        end else begin
            valid <= emit;
            sop   <= emit && (word_idx == '0);
            eop   <= emit && last;
            if (emit)
                data <= word;
        end
    end

endmodule

// File: rtl/trig_readout_ctrl.sv
module trig_readout_ctrl
    import trd_pkg::*;
#(
    parameter  int SAMPLE_W = 10,
    parameter  int WORDS    = 8,
    parameter  int PEND_W   = 2,
    parameter  int DLY_W    = 4,
    parameter  int DLY_BASE = 32,
    localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                l1_trig,
    input  logic [DLY_W-1:0]    cfg_delay,
    input  logic                cfg_test_count,
    input  logic                cfg_raw_mode,
    output logic [IDX_W-1:0]    samp_addr,
    input  logic [SAMPLE_W-1:0] pre_sample,
    input  logic [SAMPLE_W-1:0] post_sample,
    output logic                pkt_valid,
    output logic [SAMPLE_W:0]   pkt_data,
    output logic                pkt_sop,
    output logic                pkt_eop,
    output logic                pend_ovf
);
    logic       start, have_pend, dly_done, emit, last, second_pkt;
    rd_cfg_t    cfg_in, cfg_q;
    logic [IDX_W-1:0] word_idx;

    assign cfg_in.raw  = cfg_raw_mode;
    assign cfg_in.test = cfg_test_count;

    trd_trig_queue #(.PEND_W(PEND_W)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .trig      (l1_trig),
        .start     (start),
        .have_pend (have_pend),
        .ovf       (pend_ovf)
    );

    trd_delay #(.DLY_W(DLY_W), .DLY_BASE(DLY_BASE)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .dly  (cfg_delay),
        .done (dly_done)
    );

    trd_seq #(.WORDS(WORDS), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .trig       (l1_trig),
        .have_pend  (have_pend),
        .dly_done   (dly_done),
        .cfg_in     (cfg_in),
        .start      (start),
        .emit       (emit),
        .last       (last),
        .word_idx   (word_idx),
        .second_pkt (second_pkt),
        .cfg_q      (cfg_q)
    );

    assign samp_addr = word_idx;

    trd_word_gen #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_fmt (
        .clk        (clk),
        .rst        (rst),
        .emit       (emit),
        .last       (last),
        .word_idx   (word_idx),
        .second_pkt (second_pkt),
        .cfg        (cfg_q),
        .pre        (pre_sample),
        .post       (post_sample),
        .valid      (pkt_valid),
        .data       (pkt_data),
        .sop        (pkt_sop),
        .eop        (pkt_eop)
    );

endmodule

// File: rtl/trd_checker.sv
module trd_checker #(
    parameter int WORDS = 8
) (
    input logic clk,
    input logic rst,
    input logic pkt_valid,
    input logic pkt_sop,
    input logic pkt_eop,
    input logic pend_ovf
);
    int unsigned wcnt;
    int unsigned cur_idx;

    assign cur_idx = pkt_sop ? 0 : wcnt;

    always_ff @(posedge clk) begin
        if (rst)
            wcnt <= 0;
        else if (pkt_valid)
            wcnt <= cur_idx + 1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!pkt_valid && !pkt_sop && !pkt_eop && !pend_ovf));

    a_r6_sop_valid: assert property (@(posedge clk) disable iff (rst)
        pkt_sop |-> pkt_valid);

    a_r6_eop_valid: assert property (@(posedge clk) disable iff (rst)
        pkt_eop |-> pkt_valid);

    a_r6_no_gap: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_eop) |=> (pkt_valid && !pkt_sop));

    a_r6_after_end: assert property (@(posedge clk) disable iff (rst)
        pkt_eop |=> (!pkt_valid || pkt_sop));

    a_r3_length: assert property (@(posedge clk) disable iff (rst)
        pkt_eop |-> (cur_idx == WORDS - 1));

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        pend_ovf |=> pend_ovf);

endmodule

bind trig_readout_ctrl trd_checker #(.WORDS(WORDS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pkt_valid (pkt_valid),
    .pkt_sop   (pkt_sop),
    .pkt_eop   (pkt_eop),
    .pend_ovf  (pend_ovf)
);

// File: tb/sim_trig_readout_ctrl.sv
`timescale 1ns/1ps
module sim_trig_readout_ctrl;
    localparam int SW = 10;
    localparam int NW = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          l1_trig = 1'b0;
    logic [3:0]    cfg_delay = 4'd0;
    logic          cfg_test_count = 1'b0;
    logic          cfg_raw_mode = 1'b0;
    logic [IW-1:0] samp_addr;
    logic [SW-1:0] pre_sample, post_sample;
    logic          pkt_valid, pkt_sop, pkt_eop, pend_ovf;
    logic [SW:0]   pkt_data;

    int checks = 0;
    int errors = 0;
    int pat = 0;
    int seed = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    trig_readout_ctrl u0 (
        .clk(clk), .rst(rst), .l1_trig(l1_trig), .cfg_delay(cfg_delay),
        .cfg_test_count(cfg_test_count), .cfg_raw_mode(cfg_raw_mode),
        .samp_addr(samp_addr), .pre_sample(pre_sample), .post_sample(post_sample),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_sop(pkt_sop),
        .pkt_eop(pkt_eop), .pend_ovf(pend_ovf)
    );

    function automatic logic [SW-1:0] pre_of(input int i);
        int v;
        case (pat)
            0: v = seed * 7 + i * 37;
            1: v = 1023;
            2: v = 0;
            default: v = i * 3;
        endcase
        return SW'(v & 1023);
    endfunction

    function automatic logic [SW-1:0] post_of(input int i);
        int v;
        case (pat)
            0: v = seed * 13 + i * 101 + 5;
            1: v = 0;
            2: v = 1023;
            default: v = 1023 - i;
        endcase
        return SW'(v & 1023);
    endfunction

    always_comb begin
        pre_sample  = pre_of(int'(samp_addr));
        post_sample = post_of(int'(samp_addr));
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_trig();
        @(negedge clk) l1_trig = 1'b1;
        @(negedge clk) l1_trig = 1'b0;
    endtask

    task automatic wait_valid(output int k);
        k = 0;
        while (!pkt_valid && k < 400) begin
            @(negedge clk);
            k++;
        end
    endtask

    // kind: 0 diff, 1 pre, 2 post, 3 count; starts at the negedge of word 0
    task automatic get_packet(input int kind, input string tag);
        for (int i = 0; i < NW; i++) begin
            logic [SW:0] e;
            bit ok;
            case (kind)
                0: e = {1'b0, post_of(i)} - {1'b0, pre_of(i)};
                1: e = {1'b0, pre_of(i)};
                2: e = {1'b0, post_of(i)};
                default: e = (SW+1)'(i + 1);
            endcase
            ok = pkt_valid && (pkt_sop == (i == 0)) && (pkt_eop == (i == NW - 1))
                 && (pkt_data == e);
            check(ok, $sformatf("%s word %0d v%0b s%0b e%0b", tag, i, pkt_valid, pkt_sop, pkt_eop),
                  int'(pkt_data), int'(e));
            if (i < NW - 1) @(negedge clk);
        end
    endtask

    task automatic expect_quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pkt_valid) seen++;
        end
        check(seen == 0, tag, seen, 0);
    endtask

    task automatic t_reset();
        check(!pkt_valid && !pkt_sop && !pkt_eop && !pend_ovf, "R1 reset outputs",
              int'({pkt_valid, pkt_sop, pkt_eop, pend_ovf}), 0);
    endtask

    task automatic t_latency(input int dly, input int p, input int s);
        int k;
        pat = p; seed = s; cfg_delay = 4'(dly); cfg_raw_mode = 0; cfg_test_count = 0;
        pulse_trig();
        wait_valid(k);
        check(k == 32 + dly, $sformatf("R2 latency delay=%0d", dly), k, 32 + dly);
        get_packet(0, "R3 R7 diff");
        expect_quiet(20, "R3 single packet");
    endtask

    task automatic t_raw();
        int k;
        pat = 0; seed = 5; cfg_delay = 4'd2; cfg_raw_mode = 1; cfg_test_count = 0;
        pulse_trig();
        wait_valid(k);
        get_packet(1, "R4 pre packet");
        @(negedge clk);
        get_packet(2, "R4 post packet");
        expect_quiet(20, "R4 only two packets");
    endtask

    task automatic t_test(input bit raw);
        int k;
        pat = 0; seed = 9; cfg_delay = 4'd1; cfg_raw_mode = raw; cfg_test_count = 1;
        pulse_trig();
        wait_valid(k);
        get_packet(3, "R5 count packet");
        if (raw) begin
            @(negedge clk);
            get_packet(3, "R5 count restart");
        end
        expect_quiet(20, "R5 packet count");
        cfg_test_count = 0; cfg_raw_mode = 0;
    endtask

    task automatic t_queue();
        int k;
        pat = 3; cfg_delay = 4'd3; cfg_raw_mode = 0; cfg_test_count = 0;
        pulse_trig();
        pulse_trig();
        wait_valid(k);
        get_packet(0, "R8 first readout");
        @(negedge clk);
        k = 1;
        while (!pkt_valid && k < 400) begin
            @(negedge clk);
            k++;
        end
        check(k == 36, "R8 gap end to start", k, 36);
        get_packet(0, "R8 queued readout");
        expect_quiet(50, "R8 no extra readout");
    endtask

    task automatic t_overflow();
        int k;
        pat = 0; seed = 3; cfg_delay = 4'd0; cfg_raw_mode = 0; cfg_test_count = 0;
        pulse_trig();
        for (int i = 0; i < 3; i++) pulse_trig();
        check(pend_ovf == 0, "R9 three pending no overflow", int'(pend_ovf), 0);
        pulse_trig();
        check(pend_ovf == 1, "R9 fourth pending overflows", int'(pend_ovf), 1);
        for (int r = 0; r < 4; r++) begin
            wait_valid(k);
            get_packet(0, $sformatf("R9 readout %0d", r));
            @(negedge clk);
        end
        expect_quiet(60, "R9 dropped trigger no readout");
        check(pend_ovf == 1, "R9 overflow sticky", int'(pend_ovf), 1);
    endtask

    task automatic t_latch();
        int k;
        pat = 0; seed = 21; cfg_delay = 4'd0; cfg_raw_mode = 0; cfg_test_count = 0;
        pulse_trig();
        cfg_delay = 4'd15; cfg_raw_mode = 1; cfg_test_count = 1;
        wait_valid(k);
        check(k == 32, "R10 delay captured", k, 32);
        get_packet(0, "R10 mode captured");
        expect_quiet(30, "R10 no second packet");
        cfg_delay = 4'd0; cfg_raw_mode = 0; cfg_test_count = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency(0, 0, 1);
        t_latency(7, 1, 0);
        t_latency(15, 2, 0);
        t_latency(4, 0, 77);
        t_raw();
        t_test(0);
        t_test(1);
        t_queue();
        t_overflow();
        t_latch();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule